// File: doc/BRIEF.md
# Lag-Tolerant Output Comparator

This block watches two output buses of the same width. One is a reference stream and the other is a candidate stream that is expected to track it. The candidate may trail the reference by a few clock cycles. A short disagreement between the two is therefore normal. Only a disagreement that lasts longer than a programmable number of cycles is treated as a fault. A design that checks many outputs at once places one instance per output or interface, including memory-side signals.

On every enabled clock cycle the two buses are sampled and compared. A run counter measures how many enabled cycles in a row the buses have differed. When that run grows past the tolerance `tol`, a sticky error flag is set. The index of the cycle that caused the error is captured, counting sampling edges from reset. The longest run seen so far is kept as a peak value.

The `en` input acts as the valid qualifier of the sampled pair. The block accepts a pair on every edge and has no ready signal, so it never applies back-pressure. Cycles with `en` low are not part of the comparison and change nothing.

Top module: `lag_cmp`

## Requirements
- R1: After reset, `err`, `run_len`, `max_run` and `first_err_cyc` are all zero.
- R2: On an edge with `en` high, `run_len` increments by one if `ref_data` differs from `cand_data`, and clears to zero if they are equal. The new value is visible right after that edge.
- R3: `err` goes high on the edge where the updated `run_len` first exceeds `tol`, and stays high until reset, even when the buses agree again later.
- R4: With `tol` equal to zero, a single enabled cycle with differing buses sets `err`.
- R5: `first_err_cyc` captures the index of the sampling edge that set `err`, where the first edge after reset release has index 0. It holds that value afterwards.
- R6: `max_run` equals the largest `run_len` value reached since reset.
- R7: On an edge with `en` low, `run_len`, `err`, `max_run` and `first_err_cyc` keep their values, whatever the buses carry.
- R8: `run_len` saturates at 2^RUN_W-1. With `tol` at that same all-ones value, `err` never sets.
- R9: A candidate that repeats the reference with a fixed lag shorter than or equal to `tol` does not raise `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Sample qualifier; low freezes all state |
| tol | input | RUN_W | Allowed consecutive mismatch cycles |
| ref_data | input | DATA_W | Reference bus |
| cand_data | input | DATA_W | Candidate bus |
| err | output | 1 | Sticky error flag |
| first_err_cyc | output | CYC_W | Edge index at which `err` set |
| max_run | output | RUN_W | Longest mismatch run seen |
| run_len | output | RUN_W | Current mismatch run |

## Verification
A wrong run count shows at `run_len` on the very next edge. It then shows at `max_run`, and it moves the edge at which `err` rises by at least one cycle. A broken enable gate shows as a change in `run_len` within one edge of a disabled mismatch. A cycle counter that is off by one shows as a wrong `first_err_cyc` as soon as the first error is captured. Every state register is directly visible at the ports one edge after the stimulus, so the bench compares all four outputs on every sampled edge.

// File: rtl/lagcmp_pkg.sv
package lagcmp_pkg;
  parameter int unsigned DEF_DATA_W = 16;
  parameter int unsigned DEF_RUN_W  = 8;
  parameter int unsigned DEF_CYC_W  = 32;
  parameter int unsigned DEF_LANE_W = 8;

  typedef enum logic {CMP_SAME = 1'b0, CMP_DIFF = 1'b1} cmp_res_e;
endpackage

// File: rtl/lagcmp_run.sv
module lagcmp_run
  import lagcmp_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned RUN_W  = DEF_RUN_W,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] ref_data,
  input  logic [DATA_W-1:0] cand_data,
  output logic [RUN_W-1:0]  run_nxt,
  output logic [RUN_W-1:0]  run_q
);
  localparam int unsigned LANES = (DATA_W + LANE_W - 1) / LANE_W;
  localparam int unsigned PAD_W = LANES * LANE_W;
  localparam logic [RUN_W-1:0] RUN_MAX = {RUN_W{1'b1}};

  logic [PAD_W-1:0] a_pad, b_pad;
  logic [LANES-1:0] lane_ne;
  cmp_res_e         res;

  assign a_pad = PAD_W'(ref_data);
  assign b_pad = PAD_W'(cand_data);

  // Wide buses are compared lane by lane, then the lane results are merged.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_ne[g] = |(a_pad[g*LANE_W +: LANE_W] ^ b_pad[g*LANE_W +: LANE_W]);
  end

  assign res = (|lane_ne) ? CMP_DIFF : CMP_SAME;

  always_comb begin
    if (!en)                  run_nxt = run_q;
    else if (res == CMP_SAME) run_nxt = '0;
    else if (run_q == RUN_MAX) run_nxt = run_q;
    else                      run_nxt = run_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_nxt;
  end
endmodule

// File: rtl/lagcmp_flag.sv
module lagcmp_flag
  import lagcmp_pkg::*;
#(
  parameter int unsigned RUN_W = DEF_RUN_W,
  parameter int unsigned CYC_W = DEF_CYC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [RUN_W-1:0] tol,
  input  logic [RUN_W-1:0] run_nxt,
  output logic             err,
  output logic [CYC_W-1:0] first_cyc
);
  logic [CYC_W-1:0] cyc_q;
  logic             trip;

  // Edge index since reset; the first edge after release carries index 0.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc_q <= '0;
    else        cyc_q <= cyc_q + 1'b1;
  end

  assign trip = en && !err && (run_nxt > tol);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err       <= 1'b0;
      first_cyc <= '0;
    end else if (trip) begin
      err       <= 1'b1;
      first_cyc <= cyc_q;
    end
  end
endmodule

// File: rtl/lagcmp_peak.sv
module lagcmp_peak
  import lagcmp_pkg::*;
#(
  parameter int unsigned RUN_W = DEF_RUN_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [RUN_W-1:0] run_nxt,
  output logic [RUN_W-1:0] peak
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     peak <= '0;
    else if (en && run_nxt > peak)  peak <= run_nxt;
  end
endmodule

// File: rtl/lag_cmp.sv
module lag_cmp
  import lagcmp_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned RUN_W  = DEF_RUN_W,
  parameter int unsigned CYC_W  = DEF_CYC_W,
  parameter int unsigned LANE_W = DEF_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [RUN_W-1:0]  tol,
  input  logic [DATA_W-1:0] ref_data,
  input  logic [DATA_W-1:0] cand_data,
  output logic              err,
  output logic [CYC_W-1:0]  first_err_cyc,
  output logic [RUN_W-1:0]  max_run,
  output logic [RUN_W-1:0]  run_len
);
  logic [RUN_W-1:0] run_nxt;

  lagcmp_run #(.DATA_W(DATA_W), .RUN_W(RUN_W), .LANE_W(LANE_W)) i_run (
    .clk(clk), .rst_n(rst_n), .en(en),
    .ref_data(ref_data), .cand_data(cand_data),
    .run_nxt(run_nxt), .run_q(run_len)
  );

  lagcmp_flag #(.RUN_W(RUN_W), .CYC_W(CYC_W)) i_flag (
    .clk(clk), .rst_n(rst_n), .en(en), .tol(tol),
    .run_nxt(run_nxt), .err(err), .first_cyc(first_err_cyc)
  );

  lagcmp_peak #(.RUN_W(RUN_W)) i_peak (
    .clk(clk), .rst_n(rst_n), .en(en),
    .run_nxt(run_nxt), .peak(max_run)
  );
endmodule

// File: rtl/lag_cmp_chk.sv
module lag_cmp_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RUN_W  = 8,
  parameter int unsigned CYC_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic [RUN_W-1:0]  tol,
  input logic [DATA_W-1:0] ref_data,
  input logic [DATA_W-1:0] cand_data,
  input logic              err,
  input logic [CYC_W-1:0]  first_err_cyc,
  input logic [RUN_W-1:0]  max_run,
  input logic [RUN_W-1:0]  run_len
);
  p_run_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ref_data == cand_data) |=> (run_len == '0));

  p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  p_rise_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> (run_len > $past(tol)));

  p_tol_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tol == '0 && ref_data != cand_data) |=> err);

  p_first_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> $stable(first_err_cyc));

  p_peak_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    max_run >= run_len);

  p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(run_len) && $stable(err) && $stable(max_run)));
endmodule

bind lag_cmp lag_cmp_chk #(.DATA_W(DATA_W), .RUN_W(RUN_W), .CYC_W(CYC_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .tol(tol),
  .ref_data(ref_data), .cand_data(cand_data), .err(err),
  .first_err_cyc(first_err_cyc), .max_run(max_run), .run_len(run_len)
);

// File: tb/test_lag_cmp.sv
module test_lag_cmp;
  localparam int DW = 16;
  localparam int RW = 8;
  localparam int CW = 32;

  typedef struct {
    logic          e;
    logic [RW-1:0] r;
    logic [RW-1:0] m;
    logic [CW-1:0] f;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [RW-1:0] tol = '0;
  logic [DW-1:0] ref_data = '0, cand_data = '0;
  logic err;
  logic [CW-1:0] first_err_cyc;
  logic [RW-1:0] max_run, run_len;

  int checks = 0, errors = 0;
  int ncyc;
  exp_t q[$];
  logic          m_e;
  logic [RW-1:0] m_r, m_m;
  logic [CW-1:0] m_f;

  always #2.5 clk = ~clk;

  lag_cmp i_lag_cmp (
    .clk(clk), .rst_n(rst_n), .en(en), .tol(tol),
    .ref_data(ref_data), .cand_data(cand_data), .err(err),
    .first_err_cyc(first_err_cyc), .max_run(max_run), .run_len(run_len)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) ncyc <= 0; else ncyc <= ncyc + 1;

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: applies one sample and pushes the expected post-edge state.
  task automatic drive(input logic e, input logic [RW-1:0] t,
                       input logic [DW-1:0] a, input logic [DW-1:0] b);
    exp_t x;
    @(negedge clk);
    en = e; tol = t; ref_data = a; cand_data = b;
    if (e) begin
      if (a != b) m_r = (m_r == 8'hFF) ? m_r : m_r + 1'b1;
      else        m_r = '0;
      if (!m_e && m_r > t) begin m_e = 1'b1; m_f = ncyc; end
      if (m_r > m_m) m_m = m_r;
    end
    x.e = m_e; x.r = m_r; x.m = m_m; x.f = m_f;
    q.push_back(x);
  endtask

  initial begin : monitor
    exp_t x;
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        x = q.pop_front();
        check("R2 run_len", run_len, x.r);
        check("R3 err", err, x.e);
        check("R6 max_run", max_run, x.m);
        check("R5 first_err_cyc", first_err_cyc, x.f);
      end
    end
  end

  task automatic do_reset();
    wait (q.size() == 0);
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    m_e = 0; m_r = '0; m_m = '0; m_f = '0;
    repeat (2) @(negedge clk);
    check("R1 err", err, 0);
    check("R1 run_len", run_len, 0);
    check("R1 max_run", max_run, 0);
    check("R1 first_err_cyc", first_err_cyc, 0);
    rst_n = 1'b1;
  endtask

  initial begin : watchdog
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual running expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R2: equal samples keep the run at zero
    for (int i = 0; i < 4; i++) drive(1, 8'd3, 16'h1000 + i, 16'h1000 + i);
    // R9: candidate lags by two cycles, tolerance two, ref steps every 6 cycles
    begin
      logic [DW-1:0] hist[3];
      for (int k = 0; k < 3; k++) hist[k] = 16'h0;
      for (int i = 0; i < 36; i++) begin
        logic [DW-1:0] rv;
        rv = 16'h0 + 16'(i / 6) * 16'h0101;
        drive(1, 8'd2, rv, hist[1]);
        hist[1] = hist[0]; hist[0] = rv;
      end
    end
    check("R9 no err on bounded lag", err, 0);
    // R2/R6: three mismatches then agreement, tolerance three
    for (int i = 0; i < 3; i++) drive(1, 8'd3, 16'hAAAA, 16'h5555);
    drive(1, 8'd3, 16'h1, 16'h1);
    // R7: disabled mismatches change nothing
    drive(1, 8'd3, 16'hAAAA, 16'h5554);
    for (int i = 0; i < 5; i++) drive(0, 8'd0, 16'hFFFF, 16'h0000);
    // R3/R5: run continues to four and trips at tolerance three
    for (int i = 0; i < 3; i++) drive(1, 8'd3, 16'h0F0F, 16'h0F0E);
    // R3 sticky: agreement afterwards leaves err high
    for (int i = 0; i < 3; i++) drive(1, 8'd3, 16'h2222, 16'h2222);
    // R7: disabled cycles after error keep first_err_cyc
    for (int i = 0; i < 3; i++) drive(0, 8'd3, 16'h1, 16'h2);

    // R4: tolerance zero trips on one mismatch (upper lane only)
    do_reset();
    drive(1, 8'd0, 16'h3333, 16'h3333);
    drive(1, 8'd0, 16'h8000, 16'h0000);
    drive(1, 8'd0, 16'h4, 16'h4);

    // R8: saturation with all-ones tolerance never errs
    do_reset();
    for (int i = 0; i < 300; i++) drive(1, 8'hFF, 16'(i), 16'(i) ^ 16'h0040);
    wait (q.size() == 0);
    #2;
    check("R8 run saturated", run_len, 255);
    check("R8 no err at full tolerance", err, 0);

    wait (q.size() == 0);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule